// File: doc/BRIEF.md
# Serial ADC Slave Interface with Data-Ready

This block is the digital serial port on the device side of a delta-sigma converter. A controller drives chip select (active low), a serial clock and a data-in line. The block drives one data-out line, and that line also signals when a result is ready. A behavioural converter stub posts 16-bit results with a one-cycle valid strobe. On every transaction the block sends out a result, most significant bit first, and at the same time shifts in a new configuration word. The serial clock uses mode 1: it idles low, outbound data changes on its rising edges, and inbound data is sampled on its falling edges.

All pins are synchronized into the system clock, and their edges are detected there. A three-state machine controls the transaction:

- `ST_IDLE`: deselected.
- `ST_XFER`: selected and shifting.
- `ST_ABORT`: a clock stall was seen, and the block waits for deselect.

The transitions are:

- `ST_IDLE` to `ST_XFER` on a chip-select fall.
- `ST_XFER` to `ST_IDLE` on a chip-select rise.
- `ST_XFER` to `ST_ABORT` when the serial clock stays low longer than the stall limit.
- `ST_ABORT` to `ST_IDLE` on a chip-select rise.

The moment the block is selected, the data-out line shows whether an unread result exists. While the block is deselected, the pin is released and is either weakly pulled high or left floating, as one configuration bit selects.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdo_en` is 0, `cfg_word` equals `CFG_RESET` (default 16'h0008), and `sdo_pull` equals bit `PU_BIT` (default 3) of that word, which is 1.
- R2: When chip select falls and an unread result exists, `sdo` is driven low.
- R3: When chip select falls and no unread result exists, `sdo` is driven high, and the transaction returns the most recently read result again.
- R4: From the first rising serial-clock edge on, `sdo` sends the 16-bit result MSB first. Clocks 17 to 32 send the configuration word as it stood at select time, MSB first.
- R5: Data-in is sampled on falling edges. If exactly 16 falling edges occurred before deselect, the first 16 bits become `cfg_word`. If exactly 32 occurred, bits 17 to 32 become `cfg_word`.
- R6: Any other count of falling edges (for example 8 or 20) leaves `cfg_word` unchanged.
- R7: The unread flag is cleared on the 16th falling edge of a transaction that began with the flag set.
- R8: A result posted during a transaction does not alter that transaction's output. The next select shows it as unread (low) and returns it.
- R9: While deselected, `sdo_en` is 0 even when a result arrives. `sdo_pull` is 1 when config bit `PU_BIT` is 1 and 0 when it is 0 (high impedance).
- R10: If the serial clock stays low while selected for more than `CLK_KHZ*STALL_MS` system cycles, the pin is released and the transaction commits nothing. A shorter stall has no effect.
- R11: A result posted in the same cycle as the 16th falling edge that would clear the unread flag keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the controller |
| din | input | 1 | Serial data in |
| sdo | output | 1 | Data-out / data-ready value |
| sdo_en | output | 1 | Data-out driver enable |
| sdo_pull | output | 1 | Weak pull-up active on the data-out pin |
| conv_data | input | 16 | Result from the converter stub |
| conv_valid | input | 1 | One-cycle strobe: conv_data is a new result |
| cfg_word | output | 16 | Committed configuration word |

## Verification
Two functions can fall in the same clock cycle: a new result arriving from the converter, and the unread flag being cleared by the 16th falling serial-clock edge. The bench counts the synchronizer and edge-detect stages so that it raises `conv_valid` in exactly the cycle in which the 16th falling edge is registered. It then opens a new transaction. The indicator must be low there, and the new result must be returned, which shows that setting the flag won over clearing it. A second coincidence is a result posted mid-transaction: that transaction must still return the old word.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_ABORT = 2'd2
    } sp_state_e;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= RST_VAL;
            q  <= RST_VAL;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/sp_stall_timer.sv
module sp_stall_timer #(
    parameter int LIMIT = 7000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(LIMIT));
endmodule

// File: rtl/sp_shift.sv
module sp_shift #(
    parameter int TXW = 32,
    parameter int RXW = 16,
    parameter int NW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [TXW-1:0] load_val,
    input  logic           rise,
    input  logic           fall,
    input  logic           din,
    output logic           tx_top,
    output logic [RXW-1:0] rx_word,
    output logic [NW-1:0]  nfall
);
    logic [TXW-1:0] tx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx      <= '0;
            rx_word <= '0;
            nfall   <= '0;
        end else if (load) begin
            tx      <= load_val;
            rx_word <= '0;
            nfall   <= '0;
        end else begin
            if (rise)
                tx <= {tx[TXW-2:0], 1'b0};
            if (fall) begin
                rx_word <= {rx_word[RXW-2:0], din};
                if (nfall != {NW{1'b1}})
                    nfall <= nfall + 1'b1;
            end
        end
    end

    assign tx_top = tx[TXW-1];
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          CLK_KHZ   = 250000,
    parameter int          STALL_MS  = 28,
    parameter int          PU_BIT    = 3,
    parameter logic [15:0] CFG_RESET = 16'h0008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          din,
    output logic          sdo,
    output logic          sdo_en,
    output logic          sdo_pull,
    input  logic [DW-1:0] conv_data,
    input  logic          conv_valid,
    output logic [DW-1:0] cfg_word
);
    localparam int LIMIT = CLK_KHZ * STALL_MS;
    localparam int TXW   = 2 * DW;
    localparam int NW    = $clog2(TXW + 1) + 1;

    sp_state_e state, state_nx;

    logic cs_s, sck_s, din_s, cs_q, sck_q;
    logic cs_fall, cs_rise, sck_rise, sck_fall;
    logic start, in_xfer, expired, tx_top, out_bit;
    logic fresh, pend_clr, clear_hit;
    logic [DW-1:0] latest, rx_word;
    logic [NW-1:0] nfall;

    sp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, din}),
        .q     ({cs_s, sck_s, din_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
        end
    end

    assign cs_fall  = cs_q & ~cs_s;
    assign cs_rise  = ~cs_q & cs_s;
    assign sck_rise = ~sck_q & sck_s;
    assign sck_fall = sck_q & ~sck_s;
    assign in_xfer  = (state == ST_XFER);
    assign start    = (state == ST_IDLE) && cs_fall;

    sp_stall_timer #(.LIMIT(LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_xfer && !sck_s),
        .expired (expired)
    );

    sp_shift #(.TXW(TXW), .RXW(DW), .NW(NW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val ({latest, cfg_word}),
        .rise     (in_xfer && sck_rise),
        .fall     (in_xfer && sck_fall),
        .din      (din_s),
        .tx_top   (tx_top),
        .rx_word  (rx_word),
        .nfall    (nfall)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_nx = ST_XFER;
            ST_XFER:  if (cs_rise) state_nx = ST_IDLE;
                      else if (expired) state_nx = ST_ABORT;
            ST_ABORT: if (cs_rise) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // result holding and unread flag
    assign clear_hit = in_xfer && sck_fall && pend_clr &&
                       (nfall == NW'(DW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latest   <= '0;
            fresh    <= 1'b0;
            pend_clr <= 1'b0;
        end else begin
            if (conv_valid)
                latest <= conv_data;
            if (conv_valid)
                fresh <= 1'b1;
            else if (clear_hit)
                fresh <= 1'b0;
            if (start)
                pend_clr <= fresh & ~conv_valid;
            else if (conv_valid || clear_hit)
                pend_clr <= 1'b0;
        end
    end

    // configuration commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_word <= CFG_RESET;
        else if (in_xfer && cs_rise &&
                 (nfall == NW'(DW) || nfall == NW'(TXW)))
            cfg_word <= rx_word;
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_bit <= 1'b1;
        else if (start)
            out_bit <= ~fresh;
        else if (in_xfer && sck_rise)
            out_bit <= tx_top;
    end

    assign sdo_en   = in_xfer;
    assign sdo      = in_xfer & out_bit;
    assign sdo_pull = !in_xfer && cfg_word[PU_BIT];
endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk
    import adc_sp_pkg::*;
#(
    parameter int DW = 16,
    parameter int NW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sdo,
    input logic          sdo_en,
    input logic          sdo_pull,
    input logic          conv_valid,
    input logic [DW-1:0] cfg_word,
    input logic          fresh,
    input logic [NW-1:0] nfall,
    input logic          expired,
    input sp_state_e     state
);
    // R9
    deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en);

    // R9
    drive_or_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> !sdo_pull);

    // R2 R3
    select_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> (sdo == !$past(fresh)));

    // R5 R6
    cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_word) |-> ($past(nfall) == NW'(DW) || $past(nfall) == NW'(2 * DW)));

    // R11
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fresh) |-> !$past(conv_valid));

    // R10
    stall_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && state == ST_XFER) |=> !sdo_en);
endmodule

bind adc_serial_port adc_sp_chk #(.DW(DW), .NW(NW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .sdo_pull   (sdo_pull),
    .conv_valid (conv_valid),
    .cfg_word   (cfg_word),
    .fresh      (fresh),
    .nfall      (nfall),
    .expired    (expired),
    .state      (state)
);

// File: tb/sim_adc_serial_port.sv
`timescale 1ns/1ps
module sim_adc_serial_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, conv_valid = 1'b0;
    logic [15:0] conv_data = '0;
    logic sdo, sdo_en, sdo_pull;
    logic [15:0] cfg_word;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    adc_serial_port #(.CLK_KHZ(10), .STALL_MS(28)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sdo(sdo), .sdo_en(sdo_en), .sdo_pull(sdo_pull),
        .conv_data(conv_data), .conv_valid(conv_valid), .cfg_word(cfg_word)
    );

    typedef struct packed {
        logic        post_en;
        logic [15:0] pval;
        logic [5:0]  nclk;
        logic [31:0] dw;
        logic        exp_ind;
        logic [31:0] exp_rd;
        logic [15:0] exp_cfg;
    } row_t;

    localparam row_t TBL [6] = '{
        '{1'b1, 16'h1234, 6'd16, 32'h01080000, 1'b0, 32'h00001234, 16'h0108},
        '{1'b0, 16'h0000, 6'd16, 32'h02080000, 1'b1, 32'h00001234, 16'h0208},
        '{1'b1, 16'hA5C3, 6'd32, 32'hFFFF0C08, 1'b0, 32'hA5C30208, 16'h0C08},
        '{1'b0, 16'h0000, 6'd8,  32'h55555555, 1'b1, 32'h000000A5, 16'h0C08},
        '{1'b1, 16'h8001, 6'd20, 32'h00000000, 1'b0, 32'h00080010, 16'h0C08},
        '{1'b0, 16'h0000, 6'd16, 32'h7FF80000, 1'b1, 32'h00008001, 16'h7FF8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic post(input logic [15:0] v);
        @(negedge clk); conv_data = v; conv_valid = 1'b1;
        @(negedge clk); conv_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer(input int nclk, input logic [31:0] dw,
                        input int post_at, input logic [15:0] pval,
                        input int stall_at, input int stall_len,
                        output logic ind, output logic en0,
                        output logic [31:0] rd, output logic en_stall);
        rd = '0; en_stall = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        repeat (8) @(negedge clk);
        ind = sdo; en0 = sdo_en;
        for (int i = 0; i < nclk; i++) begin
            sclk = 1'b1; din = dw[31 - i];
            repeat (8) @(negedge clk);
            rd = {rd[30:0], sdo};
            sclk = 1'b0;
            if (i + 1 == post_at) begin
                repeat (2) @(negedge clk);
                conv_data = pval; conv_valid = 1'b1;
                @(negedge clk); conv_valid = 1'b0;
                repeat (5) @(negedge clk);
            end else begin
                repeat (8) @(negedge clk);
            end
            if (i + 1 == stall_at) begin
                repeat (stall_len) @(negedge clk);
                en_stall = sdo_en;
            end
        end
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic ind, en0, en_s;
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 sdo_en", {31'b0, sdo_en}, 32'h0);
        check("R1 cfg", {16'h0, cfg_word}, 32'h0008);
        check("R1 pull", {31'b0, sdo_pull}, 32'h1);

        // table: R2 R3 R4 R5 R6 R7
        foreach (TBL[k]) begin
            if (TBL[k].post_en) post(TBL[k].pval);
            xfer(int'(TBL[k].nclk), TBL[k].dw, 0, 16'h0, 0, 0, ind, en0, rd, en_s);
            check(TBL[k].exp_ind ? "R3 indicator" : "R2 indicator", {31'b0, ind}, {31'b0, TBL[k].exp_ind});
            check("R2 R3 driven", {31'b0, en0}, 32'h1);
            check("R4 R7 data", rd, TBL[k].exp_rd);
            check("R5 R6 cfg", {16'h0, cfg_word}, {16'h0, TBL[k].exp_cfg});
        end

        // R9 pull vs high impedance, no indication while deselected
        check("R9 pull on", {30'b0, sdo_pull, sdo_en}, 32'h2);
        xfer(16, 32'h00000000, 0, 16'h0, 0, 0, ind, en0, rd, en_s);
        check("R9 high-Z", {30'b0, sdo_pull, sdo_en}, 32'h0);
        post(16'h0F0F);
        repeat (6) @(negedge clk);
        check("R9 no ready while deselected", {31'b0, sdo_en}, 32'h0);
        xfer(16, 32'h00080000, 0, 16'h0, 0, 0, ind, en0, rd, en_s);
        check("R2 after deselect post", {31'b0, ind}, 32'h0);
        check("R4 data", rd, 32'h0F0F);

        // R8 mid-transaction result
        xfer(16, 32'h00080000, 4, 16'h3C3C, 0, 0, ind, en0, rd, en_s);
        check("R3 indicator", {31'b0, ind}, 32'h1);
        check("R8 old word kept", rd, 32'h0F0F);
        xfer(16, 32'h00080000, 0, 16'h0, 0, 0, ind, en0, rd, en_s);
        check("R8 next indicator", {31'b0, ind}, 32'h0);
        check("R8 next word", rd, 32'h3C3C);

        // R11 result in the same cycle as the clearing edge
        post(16'h1111);
        xfer(16, 32'h00080000, 16, 16'h2222, 0, 0, ind, en0, rd, en_s);
        check("R11 first word", rd, 32'h1111);
        xfer(16, 32'h00080000, 0, 16'h0, 0, 0, ind, en0, rd, en_s);
        check("R11 flag kept", {31'b0, ind}, 32'h0);
        check("R11 new word", rd, 32'h2222);
        xfer(16, 32'h00080000, 0, 16'h0, 0, 0, ind, en0, rd, en_s);
        check("R7 cleared", {31'b0, ind}, 32'h1);
        check("R3 repeat word", rd, 32'h2222);

        // R10 stall timeout
        xfer(16, 32'hF0F00000, 0, 16'h0, 3, 400, ind, en0, rd, en_s);
        check("R10 released", {31'b0, en_s}, 32'h0);
        check("R10 no commit", {16'h0, cfg_word}, 32'h0008);
        xfer(16, 32'h0A080000, 0, 16'h0, 5, 200, ind, en0, rd, en_s);
        check("R10 short stall", {31'b0, en_s}, 32'h1);
        check("R10 short commit", {16'h0, cfg_word}, 32'h0A08);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule